// File: doc/BRIEF.md
# Selectable decade pulse divider with arm/sync restart

This block turns a 10 MHz reference clock into a slow pulse train of 1000 Hz, 100 Hz, 10 Hz or 1 Hz. A 2-bit rate code picks the divide ratio (10^4 to 10^7). Every period opens with a pulse of fixed width, 100 µs (1000 reference clocks), whatever rate is selected. The rate code is read once in each period, just after the pulse, so an operator can change the rate freely while the block runs.

An operator can also align the output phase to an external once-per-second edge. Driving the arm input low while a pulse is being produced stops the divider and holds the output low. The next rising edge of the sync input restarts the period from zero with a fresh pulse. All control inputs pass through two-flop synchronizers. The restart pulse therefore rises a fixed 3 clocks after the sync edge, and the period that follows has exactly its nominal length.

Top module: `decade_pulse_divider`

## Requirements
- R1: The period is BASE_CLKS × 10^k clocks, where k is the sampled rate code (code 0 → ×1, 1 → ×10, 2 → ×100, 3 → ×1000). The counter wraps to zero after the last count and a new pulse starts at once.
- R2: The output is high for exactly PULSE_CLKS clocks at the start of every running period, at every rate.
- R3: The rate code, after its two-flop synchronizer, is latched only in the clock where the count equals PULSE_CLKS. A change made later in a period applies from the next period.
- R4: The period count never reaches the period length of the latched code.
- R5: While reset is asserted, the output is high. After reset is released (two clocks of reset synchronization), the first period runs with the output high for PULSE_CLKS+2 clocks, and the next rise comes BASE_CLKS+2 clocks after release at code 0.
- R6: A low on the arm input is accepted only while the output pulse is high. A low seen only during the low part of a period has no effect on the output timing.
- R7: Once armed, the output stays low and the counter stays at zero for as long as no sync rising edge arrives, even after the arm input returns high.
- R8: When armed, a sync rising edge restarts the divider. The output rises 3 clocks after the edge, and the following period has its nominal length and pulse width.
- R9: A sync rising edge while the divider is running is ignored and leaves the period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz nominal), block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 2 | Rate code: 0 = ×1, 1 = ×10, 2 = ×100, 3 = ×1000 of BASE_CLKS |
| arm_n | input | 1 | Active-low arm request, asynchronous |
| sync_in | input | 1 | Alignment input; a rising edge restarts an armed divider |
| pulse_out | output | 1 | Pulse train, high for PULSE_CLKS clocks at each period start |

## Verification
The assertions watch these properties on every cycle: the counter bound, the exact clock at which the pulse falls, the wrap into a new pulse, the frozen counter while armed, that the rate code changes only at the latch point, and the one-clock restart after a synchronized sync edge. Other behaviour can only be shown by the bench's scenarios, because it depends on the latency of the synchronizers at the ports. This covers the measured period at each of the four rates, a rate change in mid-period, arm lows that fall outside the pulse, sync edges while running, the 3-clock sync-to-pulse latency, and the timing after reset release.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_ARMED = 1'b1
  } dpd_state_t;

  // Period length in clocks for a rate code: base times a power of ten.
  function automatic int unsigned period_of(input logic [1:0] code,
                                            input int unsigned base);
    case (code)
      2'd0:    period_of = base;
      2'd1:    period_of = base * 10;
      2'd2:    period_of = base * 100;
      default: period_of = base * 1000;
    endcase
  endfunction

endpackage

// File: rtl/dpd_rst_sync.sv
module dpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_no  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_no  <= stage_q;
    end
  end
endmodule

// File: rtl/dpd_sync2.sv
module dpd_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dpd_core.sv
module dpd_core
  import dpd_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 1000,
  parameter int unsigned BASE_CLKS  = 10000,
  parameter int          CW         = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rate_i,
  input  logic          arm_n_i,
  input  logic          sync_rise_i,
  output logic          pulse_o,
  output logic [CW-1:0] count_o,
  output logic          armed_o,
  output logic [1:0]    code_o
);
  localparam logic [CW-1:0] PULSE_W = CW'(PULSE_CLKS);

  dpd_state_t    state_q, state_d;
  logic [CW-1:0] count_q, count_d;
  logic [1:0]    code_q;
  logic [CW-1:0] last_cnt;
  logic          in_pulse;
  logic          code_en;

  assign last_cnt = CW'(period_of(code_q, BASE_CLKS) - 1);
  assign in_pulse = (count_q < PULSE_W);
  assign code_en  = (state_q == ST_RUN) && (count_q == PULSE_W);

  // next-state logic
  always_comb begin
    state_d = state_q;
    count_d = count_q;
    case (state_q)
      ST_RUN: begin
        if (in_pulse && !arm_n_i) begin
          state_d = ST_ARMED;
          count_d = '0;
        end else if (count_q == last_cnt) begin
          count_d = '0;
        end else begin
          count_d = count_q + 1'b1;
        end
      end
      default: begin
        count_d = '0;
        if (sync_rise_i) state_d = ST_RUN;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 2'd0;
    end else if (code_en) begin
      code_q <= rate_i;
    end
  end

  assign pulse_o = (state_q == ST_RUN) && in_pulse;
  assign count_o = count_q;
  assign armed_o = (state_q == ST_ARMED);
  assign code_o  = code_q;
endmodule

// File: rtl/decade_pulse_divider.sv
module decade_pulse_divider #(
  parameter int unsigned PULSE_CLKS = 1000,
  parameter int unsigned BASE_CLKS  = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       arm_n,
  input  logic       sync_in,
  output logic       pulse_out
);
  localparam int CW = $clog2(BASE_CLKS * 1000);

  logic          rst_ni;
  logic [3:0]    ctl_s;
  logic          sync_prev_q;
  logic          sync_rise;
  logic [CW-1:0] cnt;
  logic          armed;
  logic [1:0]    code;

  dpd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  // {rate[1:0], arm_n, sync}
  dpd_sync2 #(.W(4), .RST_VAL(4'b0010)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     ({rate_sel, arm_n, sync_in}),
    .q     (ctl_s)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_prev_q <= 1'b0;
    else         sync_prev_q <= ctl_s[0];
  end

  assign sync_rise = ctl_s[0] & ~sync_prev_q;

  dpd_core #(
    .PULSE_CLKS (PULSE_CLKS),
    .BASE_CLKS  (BASE_CLKS),
    .CW         (CW)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_ni),
    .rate_i      (ctl_s[3:2]),
    .arm_n_i     (ctl_s[1]),
    .sync_rise_i (sync_rise),
    .pulse_o     (pulse_out),
    .count_o     (cnt),
    .armed_o     (armed),
    .code_o      (code)
  );
endmodule

// File: rtl/dpd_chk.sv
module dpd_chk #(
  parameter int unsigned PULSE_CLKS = 1000,
  parameter int unsigned BASE_CLKS  = 10000,
  parameter int          CW         = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pulse_out,
  input logic [CW-1:0] count,
  input logic          armed,
  input logic [1:0]    code,
  input logic          sync_rise
);
  localparam logic [CW-1:0] PULSE_W = CW'(PULSE_CLKS);

  logic [CW-1:0] per_len;
  assign per_len = CW'(dpd_pkg::period_of(code, BASE_CLKS));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count < per_len);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_out) && !armed) |-> ($past(count) == PULSE_W - 1'b1));

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && count == per_len - 1'b1) |=> (count == '0 && pulse_out));

  // R7
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (!pulse_out && count == '0));

  // R3
  code_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> ($past(count) == PULSE_W && !$past(armed)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sync_rise) |=> (!armed && pulse_out && count == '0));
endmodule

bind decade_pulse_divider dpd_chk #(
  .PULSE_CLKS (PULSE_CLKS),
  .BASE_CLKS  (BASE_CLKS),
  .CW         (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .pulse_out (pulse_out),
  .count     (cnt),
  .armed     (armed),
  .code      (code),
  .sync_rise (sync_rise)
);

// File: tb/decade_pulse_divider_test.sv
`timescale 1ns/1ps
module decade_pulse_divider_test;
  localparam int PULSE = 4;
  localparam int BASE  = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       arm_n;
  logic       sync_in;
  logic       pulse_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  decade_pulse_divider #(.PULSE_CLKS(PULSE), .BASE_CLKS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .arm_n(arm_n), .sync_in(sync_in), .pulse_out(pulse_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the negedge where the output has just risen.
  task automatic meas(output int per, output int wid);
    int lo;
    wid = 0;
    lo  = 0;
    while (pulse_out)  begin @(negedge clk); wid++; end
    while (!pulse_out) begin @(negedge clk); lo++;  end
    per = wid + lo;
  endtask

  task automatic to_rise(output int n);
    n = 0;
    while (pulse_out)  begin @(negedge clk); n++; end
    while (!pulse_out) begin @(negedge clk); n++; end
  endtask

  function automatic int exp_period(input int code);
    int p = BASE;
    for (int i = 0; i < code; i++) p = p * 10;
    return p;
  endfunction

  initial begin
    int per, wid, n, highs;
    rst_n = 1'b0; rate_sel = 2'd0; arm_n = 1'b1; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    // R5: output high during reset
    check(pulse_out == 1'b1, "R5 reset level", pulse_out, 1);
    rst_n = 1'b1;
    meas(per, wid);
    check(wid == PULSE + 2, "R5 first pulse width", wid, PULSE + 2);
    check(per == BASE + 2, "R5 first period", per, BASE + 2);

    // R1/R2: sweep all rate codes
    for (int c = 0; c < 4; c++) begin
      rate_sel = 2'(c);
      to_rise(n);
      for (int k = 0; k < 2; k++) begin
        meas(per, wid);
        check(per == exp_period(c), "R1 period", per, exp_period(c));
        check(wid == PULSE, "R2 width", wid, PULSE);
      end
    end

    // R3: change rate mid-period, effective next period
    rate_sel = 2'd0;
    to_rise(n); to_rise(n);
    repeat (10) @(negedge clk);
    rate_sel = 2'd1;
    to_rise(n);
    check(n + 10 == BASE, "R3 current period kept", n + 10, BASE);
    meas(per, wid);
    check(per == exp_period(1), "R3 next period", per, exp_period(1));
    rate_sel = 2'd0;
    to_rise(n); to_rise(n);

    // R6: arm low only during the low part is ignored
    repeat (6) @(negedge clk);
    arm_n = 1'b0;
    repeat (6) @(negedge clk);
    arm_n = 1'b1;
    to_rise(n);
    check(n + 12 == BASE, "R6 arm outside pulse ignored", n + 12, BASE);
    meas(per, wid);
    check(per == BASE && wid == PULSE, "R6 following period", per, BASE);

    // R9: sync edge while running is ignored
    repeat (8) @(negedge clk);
    sync_in = 1'b1;
    repeat (3) @(negedge clk);
    sync_in = 1'b0;
    to_rise(n);
    check(n + 11 == BASE, "R9 sync while running", n + 11, BASE);

    // R7: arm during the pulse freezes the output low
    arm_n = 1'b0;
    repeat (4) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pulse_out) highs++;
    end
    check(highs == 0, "R7 held low while armed", highs, 0);
    arm_n = 1'b1;
    highs = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pulse_out) highs++;
    end
    check(highs == 0, "R7 held low after arm release", highs, 0);

    // R8: sync edge restarts after a fixed 3-clock latency
    sync_in = 1'b1;
    n = 0;
    while (!pulse_out && n < 20) begin @(negedge clk); n++; end
    check(n == 3, "R8 sync latency", n, 3);
    meas(per, wid);
    check(per == BASE, "R8 period after sync", per, BASE);
    check(wid == PULSE, "R8 width after sync", wid, PULSE);
    sync_in = 1'b0;
    meas(per, wid);
    check(per == BASE, "R8 second period after sync", per, BASE);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule